// File: doc/BRIEF.md
# Counter Match Output Enable Controller

This block keeps the enable state of the compare-match outputs that belong to four hardware up/down counters. The counters and their comparators sit outside it. Each counter reports its match condition as an input level. The block drives one registered physical output per counter and shows each enable state on a status flag.

Software controls the block with a 16-bit command word and a single-cycle strobe. Bits 15:8 of the word name the counter and bits 7:0 give the operation. Before the block acts on a command, it checks the command against several configuration inputs: the counting mode of each counter, whether each counter can drive an output, and whether the device is the small variant that lacks counter 4. A command that fails any of these checks changes no state and sets a registered error flag.

A run/stop input and a stop-behaviour select input decide what the outputs do while the processor is halted. The outputs either keep their value or are forced off.

Top module: `coin_out_ctrl`

## Requirements
- R1: On a strobe, the block decodes the command word. Bits 15:8 select counter n, and only 0x01..0x04 are valid. Bits 7:0 give the operation: 0x00 disables and 0x01 enables. A valid command updates `enable_flag[n-1]` at the clock edge that samples the strobe.
- R2: A counter field outside 0x01..0x04, or an operation outside 0x00..0x01, sets `data_err`. No enable flag and no output changes.
- R3: `cnt_mode[2i+1:2i]` gives the mode of counter i+1: 1 is single-phase and 2 is two-phase. Any other code (0 or 3) on the selected counter rejects the command as in R2.
- R4: While `small_variant` is high, a command to counter 4 is rejected as in R2.
- R5: While `out_cap[i]` is low, a command to counter i+1 is rejected as in R2.
- R6: A valid disable command clears the counter's match output at the same edge that clears its enable flag. This applies while running and while stopped.
- R7: A valid enable command for a counter whose match input is already high sets its output at the same edge, provided `cpu_run` is high.
- R8: While `cpu_run` is high, `match_out[i]` is a registered copy of `enable_flag` AND `match_in[i]`. It follows `match_in[i]` with one cycle of latency.
- R9: While `cpu_run` is low and `stop_hold` is high, every match output keeps its value whatever `match_in` does. The only exception is the disable of R6.
- R10: While `cpu_run` is low and `stop_hold` is low, every match output is 0 from the next clock edge on.
- R11: Reset clears every enable flag, every output and `data_err`. `data_err` is set by a rejected strobe, cleared by an accepted strobe, and held when no strobe arrives.
- R12: An accepted command changes only the selected counter's enable flag. The other counters' flags stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_word | input | 16 | Command: counter number in 15:8, operation in 7:0 |
| cnt_mode | input | 8 | Two-bit mode code per counter |
| out_cap | input | 4 | Per-counter: counter is able to drive an output |
| small_variant | input | 1 | Counter 4 absent |
| match_in | input | 4 | Match condition level per counter |
| cpu_run | input | 1 | High while the processor runs |
| stop_hold | input | 1 | While stopped: 1 holds the outputs, 0 forces them off |
| match_out | output | 4 | Registered match outputs |
| enable_flag | output | 4 | Enable state per counter |
| data_err | output | 1 | Last command was rejected |

## Verification
The hardest case to reach is a disable command that arrives while the processor is stopped with outputs held. In that case the hold must give way to the disable on that one counter, and the other held outputs must stay frozen. The stimulus first enables three counters and raises all match inputs so that the outputs latch high. It then drops the run input with hold selected, removes the match inputs, and issues the disable. One output must fall while the other two stay high. The rejection paths are reached by changing a single configuration input just before an otherwise valid command. Each rejection is followed by a valid command, which confirms both that the state was preserved and that the error flag clears.

// File: rtl/coin_pkg.sv
package coin_pkg;
    localparam int CMD_W = 16;
    localparam int SEL_W = 8;
    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF    = 2'd0,
        MODE_SINGLE = 2'd1,
        MODE_TWO    = 2'd2,
        MODE_GPIO   = 2'd3
    } cnt_mode_e;

    localparam logic [SEL_W-1:0] OP_DISABLE = 8'h00;
    localparam logic [SEL_W-1:0] OP_ENABLE  = 8'h01;
endpackage

// File: rtl/coin_cmd_check.sv
module coin_cmd_check
    import coin_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic                      cmd_valid,
    input  logic [CMD_W-1:0]          cmd_word,
    input  logic [MODE_W*NUM_CNT-1:0] cnt_mode,
    input  logic [NUM_CNT-1:0]        out_cap,
    input  logic                      small_variant,
    output logic [NUM_CNT-1:0]        wr,
    output logic                      wr_val,
    output logic                      reject
);
    logic [SEL_W-1:0] sel;
    logic [SEL_W-1:0] op;
    logic             hit;
    logic             cfg_ok;
    logic             op_ok;
    logic [NUM_CNT-1:0] sel_vec;

    assign sel = cmd_word[CMD_W-1:SEL_W];
    assign op  = cmd_word[SEL_W-1:0];

    always_comb begin
        hit     = 1'b0;
        cfg_ok  = 1'b0;
        sel_vec = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel == SEL_W'(i + 1)) begin
                hit        = 1'b1;
                sel_vec[i] = 1'b1;
                cfg_ok     = ((cnt_mode[MODE_W*i +: MODE_W] == MODE_SINGLE) ||
                              (cnt_mode[MODE_W*i +: MODE_W] == MODE_TWO)) &&
                             out_cap[i] &&
                             !(small_variant && (i == NUM_CNT - 1));
            end
        end
        op_ok  = (op == OP_DISABLE) || (op == OP_ENABLE);
        reject = cmd_valid && !(hit && op_ok && cfg_ok);
        wr     = (cmd_valid && !reject) ? sel_vec : '0;
        wr_val = (op == OP_ENABLE);
    end
endmodule

// File: rtl/coin_chan.sv
module coin_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_val,
    input  logic match,
    input  logic run,
    input  logic hold,
    output logic en_o,
    output logic out_o
);
    typedef struct packed {
        logic en;
        logic out;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) st_d.en = wr_val;
        if (run)       st_d.out = st_d.en & match;
        else if (hold) st_d.out = st_q.out & st_d.en;
        else           st_d.out = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign out_o = st_q.out;

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_val) |=> !out_o); // R6
    AST_ENABLE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_val && match && run) |=> out_o); // R7
    AST_OUT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        out_o |-> en_o); // R8
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && hold && !wr) |=> $stable(out_o)); // R9
    AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !hold) |=> !out_o); // R10
endmodule

// File: rtl/coin_out_ctrl.sv
module coin_out_ctrl
    import coin_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [CMD_W-1:0]          cmd_word,
    input  logic [MODE_W*NUM_CNT-1:0] cnt_mode,
    input  logic [NUM_CNT-1:0]        out_cap,
    input  logic                      small_variant,
    input  logic [NUM_CNT-1:0]        match_in,
    input  logic                      cpu_run,
    input  logic                      stop_hold,
    output logic [NUM_CNT-1:0]        match_out,
    output logic [NUM_CNT-1:0]        enable_flag,
    output logic                      data_err
);
    typedef struct packed {
        logic err;
    } top_t;

    top_t top_d, top_q;
    logic [NUM_CNT-1:0] wr;
    logic               wr_val;
    logic               reject;

    coin_cmd_check #(.NUM_CNT(NUM_CNT)) u_chk (
        .cmd_valid     (cmd_valid),
        .cmd_word      (cmd_word),
        .cnt_mode      (cnt_mode),
        .out_cap       (out_cap),
        .small_variant (small_variant),
        .wr            (wr),
        .wr_val        (wr_val),
        .reject        (reject)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_chan
        coin_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (wr[g]),
            .wr_val(wr_val),
            .match (match_in[g]),
            .run   (cpu_run),
            .hold  (stop_hold),
            .en_o  (enable_flag[g]),
            .out_o (match_out[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (cmd_valid) top_d.err = reject;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign data_err = top_q.err;

    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && reject) |=> $stable(enable_flag)); // R2
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && reject) |=> data_err); // R11
    AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !reject) |=> !data_err); // R11
    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr)); // R12
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(data_err)); // R11
endmodule

// File: tb/sim_coin_out_ctrl.sv
module sim_coin_out_ctrl;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [7:0]  cnt_mode = 8'b01_01_10_01;
    logic [3:0]  out_cap = 4'hF;
    logic        small_variant = 1'b0;
    logic [3:0]  match_in = '0;
    logic        cpu_run = 1'b1;
    logic        stop_hold = 1'b0;
    logic [3:0]  match_out;
    logic [3:0]  enable_flag;
    logic        data_err;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    coin_out_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .cnt_mode(cnt_mode), .out_cap(out_cap), .small_variant(small_variant),
        .match_in(match_in), .cpu_run(cpu_run), .stop_hold(stop_hold),
        .match_out(match_out), .enable_flag(enable_flag), .data_err(data_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset out", match_out, 0);
        chk("R11 reset en", enable_flag, 0);
        chk("R11 reset err", data_err, 0);
    endtask

    task automatic t_decode();
        send(16'h0101);
        chk("R1 enable ctr1", enable_flag, 4'b0001);
        chk("R1 no err", data_err, 0);
        chk("R8 no match no out", match_out, 0);
    endtask

    task automatic t_follow();
        match_in = 4'b0001;
        tick();
        chk("R8 follows match", match_out, 4'b0001);
        match_in = 4'b0000;
        tick();
        chk("R8 follows drop", match_out, 4'b0000);
    endtask

    task automatic t_enable_hit();
        match_in = 4'b0010;
        tick();
        chk("R7 off before enable", match_out, 0);
        send(16'h0201);
        chk("R7 on at accept", match_out, 4'b0010);
        chk("R12 ctr1 kept", enable_flag, 4'b0011);
    endtask

    task automatic t_disable();
        send(16'h0200);
        chk("R6 out cleared", match_out, 0);
        chk("R6 flag cleared", enable_flag, 4'b0001);
        match_in = 0;
    endtask

    task automatic t_range();
        send(16'h0501);
        chk("R2 ctr 5 err", data_err, 1);
        chk("R2 ctr 5 en kept", enable_flag, 4'b0001);
        send(16'h0001);
        chk("R2 ctr 0 err", data_err, 1);
        send(16'h0302);
        chk("R2 op 2 err", data_err, 1);
        chk("R2 op 2 en kept", enable_flag, 4'b0001);
        tick();
        chk("R11 err held", data_err, 1);
        send(16'h0301);
        chk("R11 err cleared", data_err, 0);
        chk("R12 ctr3 only", enable_flag, 4'b0101);
    endtask

    task automatic t_mode();
        cnt_mode[3:2] = 2'd0;
        send(16'h0201);
        chk("R3 mode0 err", data_err, 1);
        chk("R3 mode0 en kept", enable_flag, 4'b0101);
        cnt_mode[3:2] = 2'd3;
        send(16'h0201);
        chk("R3 mode3 err", data_err, 1);
        cnt_mode[3:2] = 2'd2;
        send(16'h0201);
        chk("R3 mode2 ok", enable_flag, 4'b0111);
        send(16'h0200);
        chk("R3 restore", enable_flag, 4'b0101);
    endtask

    task automatic t_small();
        small_variant = 1'b1;
        send(16'h0401);
        chk("R4 ctr4 err", data_err, 1);
        chk("R4 ctr4 en kept", enable_flag, 4'b0101);
        small_variant = 1'b0;
        send(16'h0401);
        chk("R4 ctr4 ok", enable_flag, 4'b1101);
        chk("R4 no err", data_err, 0);
    endtask

    task automatic t_cap();
        out_cap[0] = 1'b0;
        send(16'h0100);
        chk("R5 cap err", data_err, 1);
        chk("R5 en kept", enable_flag, 4'b1101);
        out_cap[0] = 1'b1;
    endtask

    task automatic t_hold();
        match_in = 4'hF;
        tick();
        chk("R8 three on", match_out, 4'b1101);
        cpu_run = 1'b0;
        stop_hold = 1'b1;
        match_in = 4'h0;
        tick();
        tick();
        chk("R9 held", match_out, 4'b1101);
        send(16'h0100);
        chk("R6 disable in stop", match_out, 4'b1100);
        tick();
        chk("R9 rest held", match_out, 4'b1100);
        cpu_run = 1'b1;
        tick();
        chk("R8 resume", match_out, 0);
    endtask

    task automatic t_stop_off();
        match_in = 4'hF;
        tick();
        chk("R8 on before stop", match_out, 4'b1100);
        cpu_run = 1'b0;
        stop_hold = 1'b0;
        tick();
        chk("R10 forced off", match_out, 0);
        chk("R10 flags kept", enable_flag, 4'b1100);
        cpu_run = 1'b1;
        tick();
        chk("R8 back on", match_out, 4'b1100);
    endtask

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_decode();
        t_follow();
        t_enable_hit();
        t_disable();
        t_range();
        t_mode();
        t_small();
        t_cap();
        t_hold();
        t_stop_off();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule